// File: doc/BRIEF.md
# Reconfigurable Memory Mat

A single storage tile made of a data word array and a small metadata field beside each word. Every access carries an opcode, and the opcode alone decides what the access does to the metadata and whether the metadata may veto it. The same mat can therefore act as a plain scratchpad, as tag storage with an equality comparator, as a hardware FIFO, or as a set of synchronized words guarded by full/empty flags. It also records per-word read and write sets for speculative accesses, and it can wipe a chosen metadata bit from every entry in one access.

Requests enter on a valid/ready port and each accepted request produces exactly one response on a valid/ready port, one cycle after acceptance. The mat holds one response slot. `req_ready` is high when that slot is empty or when it is being emptied in the same cycle (`rsp_ready` high). A stalled response keeps all response fields steady until it is taken. Holding `rsp_ready` high gives one access per cycle. The role input is a plain configuration pin that the surrounding logic sets between accesses.

Metadata bit positions: bit 0 is the full flag, bit 1 the read-set mark, bit 2 the write-set mark, bit 3 the tag-valid flag. Opcodes on `req_op`: 0 read, 1 write, 2 tag compare, 3 synchronized load, 4 synchronized store, 5 speculative read, 6 speculative write, 7 gang clear, 8 FIFO push, 9 FIFO pop; the codes 10 to 15 behave as a read. Role codes on `cfg_role`: 0 scratchpad, 1 tag store, 2 FIFO, 3 treated as scratchpad.

Top module: `mem_mat`

## Requirements
- R1: After reset no response is pending, `req_ready` is 1, every metadata entry reads 0 and the FIFO is empty.
- R2: A request is accepted when `req_valid` and `req_ready` are both 1; `req_ready` equals 1 exactly when `rsp_valid` is 0 or `rsp_ready` is 1; the response appears on the cycle after acceptance and its fields stay unchanged while `rsp_valid` is 1 and `rsp_ready` is 0.
- R3: Opcode 1 stores `req_wdata` and replaces the metadata with `req_wmeta`; opcode 0 (and codes 10 to 15) returns the stored word and changes nothing.
- R4: Opcode 2 returns the stored word and raises `rsp_hit` only when metadata bit 3 is 1 and the stored word equals `req_wdata`; `rsp_hit` is 0 for every other opcode.
- R5: Opcode 3 on a word with bit 0 set returns the word and clears bit 0; with bit 0 clear it sets `rsp_status` and leaves data and metadata unchanged.
- R6: Opcode 4 on a word with bit 0 clear writes the word and sets bit 0; with bit 0 set it sets `rsp_status` and leaves data and metadata unchanged.
- R7: Opcode 5 returns the word and sets bit 1; opcode 6 writes the word and sets bit 2; other metadata bits are kept.
- R8: Opcode 7 clears, in every entry, each metadata bit that is 1 in `req_wmeta`, and keeps the rest.
- R9: In role 2, opcode 8 stores `req_wdata` at the tail slot and sets its bit 0; opcode 9 returns the oldest pushed word and clears bit 0 of its slot; words come out in push order, and a full FIFO holds DEPTH words.
- R10: A push to a full FIFO or a pop from an empty FIFO sets `rsp_status` and changes neither the pointers nor the stored data.
- R11: In any role other than 2, opcodes 8 and 9 set `rsp_status` and do nothing, and the FIFO is emptied, so a later switch to role 2 starts with an empty FIFO.
- R12: `rsp_meta` carries the metadata of the accessed entry as it was before the access (the tail slot for a push, the head slot for a pop).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_role | input | 2 | Mat role: 0 scratchpad, 1 tag store, 2 FIFO |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Mat can take a request this cycle |
| req_op | input | 4 | Access opcode |
| req_addr | input | AW (10) | Word index (ignored by push and pop) |
| req_wdata | input | DATA_W (32) | Write data, or compare value for tag compare |
| req_wmeta | input | 4 | Metadata for a write, or bit mask for gang clear |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response this cycle |
| rsp_data | output | DATA_W (32) | Stored word read by the access |
| rsp_meta | output | 4 | Metadata of the entry before the access |
| rsp_hit | output | 1 | Tag compare matched |
| rsp_status | output | 1 | Synchronization or FIFO access refused |

## Verification
The bench drives synchronized loads onto empty words and stores onto full words; a mat that ignored the flag would overwrite data or hand back stale words and flip the flag. It fills the FIFO to exactly DEPTH words, then pushes once more and pops past empty; a pointer that wrapped or a counter that overflowed would lose the first word or replay old ones. Tag compares are issued both with the valid flag clear and with a mismatching value, so a comparator that ignored either half would raise a false hit. Random stalls on the response port catch a mat that lets a held response change or accepts a second request into an occupied slot, and gang clears followed by random reads catch entries the clear missed.

// File: rtl/mat_pkg.sv
package mat_pkg;
  localparam int META_W = 4;

  // metadata bit positions
  localparam int MB_FULL  = 0;
  localparam int MB_RSET  = 1;
  localparam int MB_WSET  = 2;
  localparam int MB_VALID = 3;

  typedef enum logic [3:0] {
    OP_RD   = 4'd0,
    OP_WR   = 4'd1,
    OP_TCMP = 4'd2,
    OP_SLD  = 4'd3,
    OP_SST  = 4'd4,
    OP_SPRD = 4'd5,
    OP_SPWR = 4'd6,
    OP_GANG = 4'd7,
    OP_PUSH = 4'd8,
    OP_POP  = 4'd9
  } mat_op_e;

  typedef enum logic [1:0] {
    ROLE_SCRATCH = 2'd0,
    ROLE_TAG     = 2'd1,
    ROLE_FIFO    = 2'd2
  } mat_role_e;
endpackage

// File: rtl/mat_data_ram.sv
module mat_data_ram #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [DEPTH];

  // read-first single port; output register only moves on an access
  always_ff @(posedge clk) begin
    if (en) begin
      rdata <= store[addr];
      if (we) store[addr] <= wdata;
    end
  end
endmodule

// File: rtl/mat_meta_array.sv
module mat_meta_array import mat_pkg::*; #(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     rd_addr,
  output logic [META_W-1:0] rd_meta,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [META_W-1:0] wr_meta,
  input  logic              gang_en,
  input  logic [META_W-1:0] gang_mask
);
  logic [META_W-1:0] meta [DEPTH];

  // combinational read port beside a write port: read-modify-write in one cycle
  assign rd_meta = meta[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) meta[i] <= '0;
    end else begin
      if (gang_en) begin
        for (int i = 0; i < DEPTH; i++) meta[i] <= meta[i] & ~gang_mask;
      end
      if (wr_en) meta[wr_addr] <= wr_meta;
    end
  end

  // after a gang clear, no entry carries a cleared bit until rewritten
  p_gang_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gang_en && !wr_en |=> (rd_meta & $past(gang_mask)) == '0);
endmodule

// File: rtl/mat_fifo_ptr.sv
module mat_fifo_ptr #(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  output logic [AW-1:0] head,
  output logic [AW-1:0] tail,
  output logic          full,
  output logic          empty
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic [CW-1:0] cnt;

  assign full  = (cnt == CAP);
  assign empty = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else begin
      if (push) tail <= (tail == LAST) ? '0 : tail + 1'b1;
      if (pop)  head <= (head == LAST) ? '0 : head + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  p_clr_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);
  always_ff @(posedge clk) begin
    if (rst_n) p_cnt_bound_r10: assert (cnt <= CAP);
  end
endmodule

// File: rtl/mem_mat.sv
module mem_mat import mat_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_role,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_op,
  input  logic [AW-1:0]     req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [META_W-1:0] req_wmeta,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic [META_W-1:0] rsp_meta,
  output logic              rsp_hit,
  output logic              rsp_status
);
  mat_op_e           op;
  logic              fire, is_fifo;
  logic [AW-1:0]     head, tail, acc_addr;
  logic              fifo_full, fifo_empty;
  logic [META_W-1:0] cur_meta, nxt_meta;
  logic              ram_we, meta_we, push_go, pop_go, gang_go, refuse;
  logic [DATA_W-1:0] ram_q;

  // response slot
  logic              rv_q, sts_q;
  mat_op_e           op_q;
  logic [META_W-1:0] meta_q;
  logic [DATA_W-1:0] cmp_q;

  assign op        = mat_op_e'(req_op);
  assign is_fifo   = (cfg_role == ROLE_FIFO);
  assign req_ready = !rv_q || rsp_ready;
  assign fire      = req_valid && req_ready;

  always_comb begin
    case (op)
      OP_PUSH: acc_addr = tail;
      OP_POP:  acc_addr = head;
      default: acc_addr = req_addr;
    endcase
  end

  // per-opcode metadata rule and veto
  always_comb begin
    ram_we   = 1'b0;
    meta_we  = 1'b0;
    nxt_meta = cur_meta;
    push_go  = 1'b0;
    pop_go   = 1'b0;
    gang_go  = 1'b0;
    refuse   = 1'b0;
    case (op)
      OP_WR: begin
        ram_we   = 1'b1;
        meta_we  = 1'b1;
        nxt_meta = req_wmeta;
      end
      OP_SLD: begin
        if (!cur_meta[MB_FULL]) refuse = 1'b1;
        else begin
          meta_we = 1'b1;
          nxt_meta[MB_FULL] = 1'b0;
        end
      end
      OP_SST: begin
        if (cur_meta[MB_FULL]) refuse = 1'b1;
        else begin
          ram_we  = 1'b1;
          meta_we = 1'b1;
          nxt_meta[MB_FULL] = 1'b1;
        end
      end
      OP_SPRD: begin
        meta_we = 1'b1;
        nxt_meta[MB_RSET] = 1'b1;
      end
      OP_SPWR: begin
        ram_we  = 1'b1;
        meta_we = 1'b1;
        nxt_meta[MB_WSET] = 1'b1;
      end
      OP_GANG: gang_go = 1'b1;
      OP_PUSH: begin
        if (!is_fifo || fifo_full) refuse = 1'b1;
        else begin
          ram_we  = 1'b1;
          meta_we = 1'b1;
          push_go = 1'b1;
          nxt_meta[MB_FULL] = 1'b1;
        end
      end
      OP_POP: begin
        if (!is_fifo || fifo_empty) refuse = 1'b1;
        else begin
          meta_we = 1'b1;
          pop_go  = 1'b1;
          nxt_meta[MB_FULL] = 1'b0;
        end
      end
      default: ;
    endcase
  end

  mat_data_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .en    (fire),
    .we    (fire && ram_we),
    .addr  (acc_addr),
    .wdata (req_wdata),
    .rdata (ram_q)
  );

  mat_meta_array #(.DEPTH(DEPTH)) u_meta (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_addr   (acc_addr),
    .rd_meta   (cur_meta),
    .wr_en     (fire && meta_we),
    .wr_addr   (acc_addr),
    .wr_meta   (nxt_meta),
    .gang_en   (fire && gang_go),
    .gang_mask (req_wmeta)
  );

  mat_fifo_ptr #(.DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!is_fifo),
    .push  (fire && push_go),
    .pop   (fire && pop_go),
    .head  (head),
    .tail  (tail),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rv_q   <= 1'b0;
      sts_q  <= 1'b0;
      op_q   <= OP_RD;
      meta_q <= '0;
      cmp_q  <= '0;
    end else if (fire) begin
      rv_q   <= 1'b1;
      sts_q  <= refuse;
      op_q   <= op;
      meta_q <= cur_meta;
      cmp_q  <= req_wdata;
    end else if (rsp_ready) begin
      rv_q <= 1'b0;
    end
  end

  assign rsp_valid  = rv_q;
  assign rsp_data   = ram_q;
  assign rsp_meta   = meta_q;
  assign rsp_status = sts_q;
  assign rsp_hit    = rv_q && (op_q == OP_TCMP) && meta_q[MB_VALID] && (ram_q == cmp_q);

  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);
  p_rsp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_meta)
      && $stable(rsp_status) && $stable(rsp_hit));
  p_hit_tag_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> op_q == OP_TCMP && rsp_meta[MB_VALID]);
  p_sync_ld_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && op_q == OP_SLD && !rsp_meta[MB_FULL] |-> rsp_status);
  p_sync_st_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && op_q == OP_SST && rsp_meta[MB_FULL] |-> rsp_status);
  p_fifo_role_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !is_fifo && (op == OP_PUSH || op == OP_POP) |=> rsp_status);
endmodule

// File: tb/test_mem_mat.sv
module test_mem_mat;
  localparam int DW = 32;
  localparam int DEPTH = 1024;
  localparam int AW = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_role = 2'd0;
  logic req_valid = 1'b0, rsp_ready = 1'b1;
  logic [3:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [3:0] req_wmeta = '0;
  logic req_ready, rsp_valid, rsp_hit, rsp_status;
  logic [DW-1:0] rsp_data;
  logic [3:0] rsp_meta;

  always #2.5 clk = ~clk;

  mem_mat #(.DATA_W(DW), .DEPTH(DEPTH)) i_mem_mat (
    .clk(clk), .rst_n(rst_n), .cfg_role(cfg_role),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_wmeta(req_wmeta),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_meta(rsp_meta), .rsp_hit(rsp_hit), .rsp_status(rsp_status)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model
  logic [DW-1:0] m_data [DEPTH];
  logic [3:0]    m_meta [DEPTH];
  bit            m_wr   [DEPTH];
  int m_head = 0, m_tail = 0, m_cnt = 0;

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic string req_of(int op, bit refused);
    case (op)
      1, 0: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5, 6: return "R7";
      7: return "R8";
      8, 9: return refused ? (cfg_role == 2'd2 ? "R10" : "R11") : "R9";
      default: return "R3";
    endcase
  endfunction

  function automatic int nxt(int p);
    return (p == DEPTH - 1) ? 0 : p + 1;
  endfunction

  task automatic set_role(logic [1:0] r);
    @(negedge clk);
    cfg_role = r;
    if (r != 2'd2) begin m_head = 0; m_tail = 0; m_cnt = 0; end
    @(negedge clk);
  endtask

  // one access: expected values from the model, then the model is updated
  task automatic do_op(int op, int addr, logic [31:0] wd, logic [3:0] wm);
    int a;
    bit fifo, refuse, cd, cm;
    logic [31:0] ed;
    logic [3:0] em;
    bit eh;
    logic [31:0] sd;
    logic [3:0] sm;
    logic ss, sh;
    int stall;
    fifo = (cfg_role == 2'd2);
    a = (op == 8) ? m_tail : (op == 9) ? m_head : addr;
    em = m_meta[a];
    ed = m_data[a];
    refuse = 0; cd = 0; cm = 1; eh = 0;
    case (op)
      1: begin m_data[a] = wd; m_meta[a] = wm; m_wr[a] = 1; end
      2: begin cd = m_wr[a]; eh = em[3] && m_wr[a] && (ed == wd); end
      3: if (!em[0]) refuse = 1; else begin cd = m_wr[a]; m_meta[a][0] = 0; end
      4: if (em[0]) refuse = 1; else begin m_data[a] = wd; m_wr[a] = 1; m_meta[a][0] = 1; end
      5: begin cd = m_wr[a]; m_meta[a][1] = 1; end
      6: begin m_data[a] = wd; m_wr[a] = 1; m_meta[a][2] = 1; end
      7: begin cm = 0; for (int i = 0; i < DEPTH; i++) m_meta[i] = m_meta[i] & ~wm; end
      8: if (!fifo || m_cnt == DEPTH) begin refuse = 1; cm = 0; end
         else begin m_data[a] = wd; m_wr[a] = 1; m_meta[a][0] = 1; m_tail = nxt(m_tail); m_cnt++; end
      9: if (!fifo || m_cnt == 0) begin refuse = 1; cm = 0; end
         else begin cd = 1; m_meta[a][0] = 0; m_head = nxt(m_head); m_cnt--; end
      default: cd = m_wr[a];
    endcase
    @(negedge clk);
    req_op = 4'(op); req_addr = AW'(addr); req_wdata = wd; req_wmeta = wm;
    req_valid = 1'b1; rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2", "rsp_valid after accept", 32'(rsp_valid), 32'd1);
    chk(req_of(op, refuse), "status", 32'(rsp_status), 32'(refuse));
    chk("R4", "hit", 32'(rsp_hit), 32'(eh));
    if (cm) chk("R12", "meta", 32'(rsp_meta), 32'(em));
    if (cd) chk(req_of(op, refuse), "data", rsp_data, ed);
    stall = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 3)) : 0;
    if (stall > 0) begin
      rsp_ready = 1'b0;
      sd = rsp_data; sm = rsp_meta; ss = rsp_status; sh = rsp_hit;
      for (int k = 0; k < stall; k++) begin
        @(negedge clk);
        chk("R2", "ready low while held", 32'(req_ready), 32'd0);
        chk("R2", "held rsp", {rsp_data ^ sd}, 32'd0);
        chk("R2", "held fields", {28'd0, rsp_valid, rsp_meta == sm, rsp_status == ss, rsp_hit == sh}, 32'hF);
      end
      rsp_ready = 1'b1;
    end
  endtask

  task automatic rd(int a);
    do_op(0, a, 32'd0, 4'd0);
  endtask

  initial begin
    #(5ns * 190000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) begin m_data[i] = '0; m_meta[i] = '0; m_wr[i] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    chk("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1", "req_ready", 32'(req_ready), 32'd1);
    rd(5); rd(1023);
    set_role(2'd2);
    do_op(9, 0, 0, 0);  // R1/R10: pop of empty FIFO after reset
    set_role(2'd0);

    // R3 read/write
    do_op(1, 3, 32'hDEAD_BEEF, 4'b1000); rd(3);
    // R4 tag compare: hit, mismatch, valid clear
    do_op(2, 3, 32'hDEAD_BEEF, 0);
    do_op(2, 3, 32'hDEAD_BEEE, 0);
    do_op(1, 4, 32'h1234_5678, 4'b0000);
    do_op(2, 4, 32'h1234_5678, 0);
    // R5/R6 synchronized words
    do_op(3, 7, 0, 0);                  // empty load refused
    do_op(4, 7, 32'hA5A5_0001, 0);      // store fills
    do_op(4, 7, 32'h5A5A_0002, 0);      // full store refused
    rd(7);
    do_op(3, 7, 0, 0);                  // load empties
    do_op(3, 7, 0, 0);                  // refused again
    // R7 speculative marks, R8 gang clear
    do_op(5, 3, 0, 0); do_op(6, 9, 32'h0BAD_F00D, 0); rd(3); rd(9);
    do_op(7, 0, 0, 4'b0110); rd(3); rd(9);
    // R11 FIFO ops refused outside FIFO role
    do_op(8, 0, 32'h1, 0); do_op(9, 0, 0, 0);

    // R9/R10 fill to capacity, overflow, drain in order, underflow
    set_role(2'd2);
    for (int i = 0; i < DEPTH; i++) do_op(8, 0, 32'hF000_0000 + 32'(i), 0);
    do_op(8, 0, 32'hFFFF_FFFF, 0);
    for (int i = 0; i < DEPTH; i++) do_op(9, 0, 0, 0);
    do_op(9, 0, 0, 0);
    // R11 leaving the role empties the FIFO
    for (int i = 0; i < 5; i++) do_op(8, 0, 32'(i), 0);
    set_role(2'd1);
    set_role(2'd2);
    do_op(9, 0, 0, 0);

    // random phase on a small address window
    set_role(2'd0);
    for (int i = 0; i < 32; i++) do_op(1, i, $urandom, 4'($urandom));
    for (int n = 0; n < 2500; n++) begin
      int op, a;
      logic [31:0] wd;
      if ($urandom_range(0, 199) == 0) set_role(2'($urandom_range(0, 3)));
      op = $urandom_range(0, 11);
      a  = $urandom_range(0, 31);
      wd = (op == 2 && $urandom_range(0, 1) == 1) ? m_data[a] : $urandom;
      if (op == 7 && $urandom_range(0, 3) != 0) op = 0;
      do_op(op, a, wd, 4'($urandom));
    end

    repeat (2) @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule